// File: doc/BRIEF.md
# Colour Palette Programming Port

This block is the register-level programming interface to a set of eight colour palettes of 256 entries each. Every entry holds a 9-bit colour and one priority flag. Software selects an entry with an index register and picks the palette to edit with a control register. It then writes colours through one of two data registers. The short form takes one byte and derives the missing lowest blue bit. The long form takes two bytes, which supply the full 9-bit colour and, for the bitmap-layer palettes, a priority flag.

After a completed colour write, the index steps forward by one and wraps modulo 256, unless software has turned stepping off. A debug port always shows the entry under the current palette and index. Reads have no side effects. Display-time colour lookup is not part of this block.

Top module: `pal_write_port`

## Requirements
- R1: Register codes on `reg_addr` are 0 = index, 1 = control, 2 = short colour, 3 = long colour. After reset the index reads 0 and the control register reads 0.
- R2: A write of byte d to the short colour register stores the colour {d[7:0], d[1] OR d[0]} (RRRGGGBB plus derived lowest blue bit) and clears the priority flag. Reading the short colour register returns colour bits 8:1 of the addressed entry.
- R3: After a short colour write, the index becomes index+1 modulo 256 when control bit 7 is 0. It is unchanged when control bit 7 is 1.
- R4: A long colour write takes two writes to register 3. The first write changes neither the palettes nor the index. The second write stores the colour {first[7:0], second[0]}.
- R5: On the second long write, bit 7 of that byte is stored as the priority flag only when control bits 5:4 equal 01 (palette codes 001 and 101). For every other palette the flag is stored as 0.
- R6: The index steps by one modulo 256 after the second long write only, and only when control bit 7 is 0.
- R7: Reading the long colour register returns {priority, 6'b0, colour bit 0}. No read of any register changes the index, the phase or any entry.
- R8: Control bits 6:4 select one of eight independent palettes. A write to one palette leaves the other seven unchanged.
- R9: A write to the index register, or a short colour write, returns the long-write sequence to its first byte. A control write does not.
- R10: `dbg_colour` and `dbg_prio` show the entry at the current palette and index, combinationally.
- R11: The control register reads back bits 7:4 as written. Bits 3:0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register code (see R1) |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the register on `reg_addr` |
| dbg_colour | output | 9 | Colour of the currently addressed entry |
| dbg_prio | output | 1 | Priority flag of the currently addressed entry |

## Verification
The hardest situation to reach is a long-write sequence left half finished when something else intervenes. This can be a new index, a short write or a control write, and the next byte to register 3 must then be taken as a first byte or as a second byte. The stimulus deliberately abandons a first byte in each of these ways and then writes byte values whose placement is visible in the stored colour. A misread phase therefore shows up as a wrong entry. Every palette is also filled at the wrapping end of the index range with priority bits set, so both the priority masking and the modulo-256 step are observed.

// File: rtl/pal_port_pkg.sv
// Shared definitions for the palette programming port.
// Assumes the register layout fixes palette select at 3 bits and data at 8 bits.
package pal_port_pkg;

    localparam int DATA_W   = 8;
    localparam int COL_W    = 9;
    localparam int BANK_W   = 3;
    localparam int NBANK    = 1 << BANK_W;
    localparam int ENTRY_W  = COL_W + 1;

    typedef enum logic [1:0] {
        REG_INDEX = 2'd0,
        REG_CTRL  = 2'd1,
        REG_COL8  = 2'd2,
        REG_COL9  = 2'd3
    } pal_reg_e;

    typedef struct packed {
        logic             prio;
        logic [COL_W-1:0] colour;
    } pal_entry_t;

    // Low two select bits that mark a bitmap-layer palette (codes 001 / 101).
    localparam logic [1:0] PRIO_BANK_CODE = 2'b01;

    // Build a 9-bit colour from a one-byte RRRGGGBB value.
    function automatic logic [COL_W-1:0] expand_short(input logic [DATA_W-1:0] d);
        return {d, d[1] | d[0]};
    endfunction

endpackage

// File: rtl/pal_port_regs.sv
// Register state of the palette port: index, control, long-write phase and
// latched first byte. Produces the storage write strobe and entry.
// Assumes one register access per cycle; IDX_W is at most 8.
module pal_port_regs
    import pal_port_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [IDX_W-1:0]    idx,
    output logic [BANK_W-1:0]   bank_sel,
    output logic                no_inc,
    output logic                phase_hi,
    output logic                mem_we,
    output pal_entry_t          mem_wentry
);

    logic [IDX_W-1:0]  idx_q;
    logic [BANK_W-1:0] bank_q;
    logic              no_inc_q;
    logic              phase_q;
    logic [DATA_W-1:0] first_q;

    logic wr_index, wr_ctrl, wr_short, wr_long_a, wr_long_b, step, prio_ok;

    // Decode the write strobe into per-register events.
    always_comb begin
        wr_index  = reg_wr && (reg_addr == REG_INDEX);
        wr_ctrl   = reg_wr && (reg_addr == REG_CTRL);
        wr_short  = reg_wr && (reg_addr == REG_COL8);
        wr_long_a = reg_wr && (reg_addr == REG_COL9) && !phase_q;
        wr_long_b = reg_wr && (reg_addr == REG_COL9) &&  phase_q;
        step      = (wr_short || wr_long_b) && !no_inc_q;
        prio_ok   = (bank_q[1:0] == PRIO_BANK_CODE);
    end

    // Index register: load on index write, step after a completed colour write.
    always_ff @(posedge clk) begin
        if (!rst_n)        idx_q <= '0;
        else if (wr_index) idx_q <= reg_wdata[IDX_W-1:0];
        else if (step)     idx_q <= idx_q + 1'b1;
    end

    // Control register: stepping disable and palette select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            no_inc_q <= 1'b0;
            bank_q   <= '0;
        end else if (wr_ctrl) begin
            no_inc_q <= reg_wdata[7];
            bank_q   <= reg_wdata[6:4];
        end
    end

    // Long-write phase: set by a first byte, cleared by completion or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 phase_q <= 1'b0;
        else if (wr_index || wr_short || wr_long_b) phase_q <= 1'b0;
        else if (wr_long_a)                         phase_q <= 1'b1;
    end

    // Hold the first byte of a long write until the second arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)         first_q <= '0;
        else if (wr_long_a) first_q <= reg_wdata;
    end

    // Form the entry to store for either write form.
    always_comb begin
        mem_we = wr_short || wr_long_b;
        if (wr_short) begin
            mem_wentry.prio   = 1'b0;
            mem_wentry.colour = expand_short(reg_wdata);
        end else begin
            mem_wentry.prio   = prio_ok && reg_wdata[7];
            mem_wentry.colour = {first_q, reg_wdata[0]};
        end
    end

    assign idx      = idx_q;
    assign bank_sel = bank_q;
    assign no_inc   = no_inc_q;
    assign phase_hi = phase_q;

    // R3: short write with stepping enabled moves the index by one.
    a_r3_short_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_COL8 && !no_inc_q) |=> idx_q == $past(idx_q) + 1'b1);
    // R3: stepping disabled holds the index across a short write.
    a_r3_short_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_COL8 && no_inc_q) |=> $stable(idx_q));
    // R4: first byte of a long write leaves the index alone and arms phase.
    a_r4_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_COL9 && !phase_q) |=> ($stable(idx_q) && phase_q));
    // R6: completed long write with stepping enabled moves the index by one.
    a_r6_second_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_COL9 && phase_q && !no_inc_q) |=> idx_q == $past(idx_q) + 1'b1);
    // R7: cycles without writes change no register state.
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(idx_q) && $stable(phase_q) && $stable(bank_q)));
    // R9: an index write always restarts the long-write sequence.
    a_r9_index_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_INDEX) |=> !phase_q);

endmodule

// File: rtl/pal_port_store.sv
// Eight palette banks, one generated per select code, sharing one address.
// Assumes write and read use the same bank/index (the current selection).
// No reset: entries hold whatever software wrote.
module pal_port_store
    import pal_port_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BANK_W-1:0] bank,
    input  logic [IDX_W-1:0]  addr,
    input  pal_entry_t        wentry,
    output pal_entry_t        rentry
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] bank_rd [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [ENTRY_W-1:0] mem [DEPTH];
        logic               sel_here;

        // This bank is the write target.
        assign sel_here = (bank == BANK_W'(g));

        // Store the entry when this bank is selected.
        always_ff @(posedge clk) begin
            if (we && sel_here) mem[addr] <= wentry;
        end

        assign bank_rd[g] = mem[addr];
    end

    // Pick the selected bank's entry for the read side.
    assign rentry = pal_entry_t'(bank_rd[bank]);

endmodule

// File: rtl/pal_port_rdmux.sv
// Read-data multiplexer for the four palette port registers.
// Purely combinational; reads have no side effect.
module pal_port_rdmux
    import pal_port_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [1:0]        reg_addr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              no_inc,
    input  pal_entry_t        entry,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] idx_ext;

    // Widen the index to the register width.
    always_comb begin
        idx_ext            = '0;
        idx_ext[IDX_W-1:0] = idx;
    end

    // Select the register image for the addressed code.
    always_comb begin
        case (reg_addr)
            REG_INDEX: rdata = idx_ext;
            REG_CTRL:  rdata = {no_inc, bank_sel, 4'b0000};
            REG_COL8:  rdata = entry.colour[COL_W-1:1];
            default:   rdata = {entry.prio, 6'b000000, entry.colour[0]};
        endcase
    end

endmodule

// File: rtl/pal_write_port.sv
// Top of the palette programming port: registers, banked storage, read mux
// and debug view of the currently addressed entry.
// Assumes one register access per cycle on a single clock.
module pal_write_port
    import pal_port_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic [8:0]  dbg_colour,
    output logic        dbg_prio
);

    logic [IDX_W-1:0]  idx;
    logic [BANK_W-1:0] bank_sel;
    logic              no_inc;
    logic              phase_hi;
    logic              mem_we;
    pal_entry_t        mem_wentry;
    pal_entry_t        rentry;

    pal_port_regs #(.IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .idx        (idx),
        .bank_sel   (bank_sel),
        .no_inc     (no_inc),
        .phase_hi   (phase_hi),
        .mem_we     (mem_we),
        .mem_wentry (mem_wentry)
    );

    pal_port_store #(.IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .we     (mem_we),
        .bank   (bank_sel),
        .addr   (idx),
        .wentry (mem_wentry),
        .rentry (rentry)
    );

    pal_port_rdmux #(.IDX_W(IDX_W)) u_rdmux (
        .reg_addr (reg_addr),
        .idx      (idx),
        .bank_sel (bank_sel),
        .no_inc   (no_inc),
        .entry    (rentry),
        .rdata    (reg_rdata)
    );

    assign dbg_colour = rentry.colour;
    assign dbg_prio   = rentry.prio;

    // R2: with stepping off, a short write is visible at once on the debug view.
    a_r2_short_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_COL8 && no_inc) |=>
        (dbg_colour == {$past(reg_wdata), $past(reg_wdata[1]) | $past(reg_wdata[0])}) && !dbg_prio);
    // R5: outside the bitmap palettes a completed long write never sets priority.
    a_r5_prio_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_COL9 && phase_hi && no_inc && bank_sel[1:0] != PRIO_BANK_CODE)
        |=> !dbg_prio);
    // R4: long write with stepping off stores first byte and bit 0 of second.
    a_r4_long_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_COL9 && phase_hi && no_inc) |=>
        dbg_colour[0] == $past(reg_wdata[0]));

endmodule

// File: tb/pal_write_port_bench.sv
module pal_write_port_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [8:0] dbg_colour;
    logic       dbg_prio;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [8:0] exp_col [8*256];
    logic       exp_pri [8*256];

    always #5 clk = ~clk;

    pal_write_port u_pal_write_port (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dbg_colour(dbg_colour), .dbg_prio(dbg_prio)
    );

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // Read back an entry via index, both colour registers and the debug view.
    task automatic verify_entry(input int b, input logic [7:0] i, input string req);
        logic [7:0] v;
        wr(2'd0, i);
        rd(2'd2, v);
        chk({req, " short read"}, {2'b0, v}, {2'b0, exp_col[b*256+i][8:1]});
        rd(2'd3, v);
        chk({req, " long read R7"}, {2'b0, v}, {2'b0, exp_pri[b*256+i], 6'b0, exp_col[b*256+i][0]});
        chk({req, " debug R10"}, {dbg_prio, dbg_colour}, {exp_pri[b*256+i], exp_col[b*256+i]});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] second;
        reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = 8'h00; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of index and control.
        rd(2'd0, v); chk("R1 index reset", {2'b0, v}, 10'h000);
        rd(2'd1, v); chk("R1 ctrl reset", {2'b0, v}, 10'h000);

        // R2 R3: fill palette 0 with every byte value using short writes.
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        for (int d = 0; d < 256; d++) begin
            wr(2'd2, 8'(d));
            exp_col[d] = {8'(d), (d[1] | d[0])};
            exp_pri[d] = 1'b0;
        end
        rd(2'd0, v); chk("R3 index wrapped", {2'b0, v}, 10'h000);
        for (int i = 0; i < 256; i++) verify_entry(0, 8'(i), "R2");

        // R3 R11: stepping disabled; control readback of low bits.
        wr(2'd1, 8'h80);
        wr(2'd0, 8'd5);
        wr(2'd2, 8'h12);
        exp_col[5] = {8'h12, 1'b1}; exp_pri[5] = 1'b0;
        rd(2'd0, v); chk("R3 no step", {2'b0, v}, 10'd5);
        chk("R2 stored no step", {dbg_prio, dbg_colour}, {1'b0, 9'h025});
        rd(2'd1, v); chk("R11 ctrl readback", {2'b0, v}, 10'h080);
        wr(2'd1, 8'hAF);
        rd(2'd1, v); chk("R11 low bits zero", {2'b0, v}, 10'h0A0);

        // R4 R5 R6 R8: long writes into every palette across the wrap point.
        for (int b = 0; b < 8; b++) begin
            wr(2'd1, 8'(b << 4));
            wr(2'd0, 8'd250);
            for (int k = 0; k < 8; k++) begin
                logic [7:0] first;
                logic [7:0] ix;
                first  = 8'(b * 32 + k * 3 + 1);
                second = {k[0], 6'b0, k[1]};
                ix     = 8'(250 + k);
                wr(2'd3, first);
                rd(2'd0, v); chk("R4 first byte holds index", {2'b0, v}, {2'b0, ix});
                wr(2'd3, second);
                exp_col[b*256+ix] = {first, second[0]};
                exp_pri[b*256+ix] = ((b & 3) == 1) ? second[7] : 1'b0;
            end
            rd(2'd0, v); chk("R6 index stepped and wrapped", {2'b0, v}, 10'd2);
        end
        for (int b = 0; b < 8; b++) begin
            wr(2'd1, 8'(b << 4));
            for (int k = 0; k < 8; k++) verify_entry(b, 8'(250 + k), "R5 R8");
        end
        wr(2'd1, 8'h00);
        verify_entry(0, 8'd100, "R8 untouched entry");

        // R9: index write restarts the long sequence.
        wr(2'd0, 8'd10);
        wr(2'd3, 8'hAA);
        wr(2'd0, 8'd10);
        wr(2'd3, 8'h55);
        wr(2'd3, 8'h01);
        exp_col[10] = {8'h55, 1'b1}; exp_pri[10] = 1'b0;
        verify_entry(0, 8'd10, "R9 index restart");
        // R9: short write restarts the long sequence.
        wr(2'd0, 8'd20);
        wr(2'd3, 8'h33);
        wr(2'd2, 8'h44);
        wr(2'd3, 8'h66);
        wr(2'd3, 8'h01);
        exp_col[20] = {8'h44, 1'b0}; exp_pri[20] = 1'b0;
        exp_col[21] = {8'h66, 1'b1}; exp_pri[21] = 1'b0;
        rd(2'd0, v); chk("R9 index after pair", {2'b0, v}, 10'd22);
        verify_entry(0, 8'd20, "R9 short restart");
        verify_entry(0, 8'd21, "R9 short restart");
        // R9: control write keeps the pending first byte.
        wr(2'd0, 8'd30);
        wr(2'd3, 8'h77);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h01);
        exp_col[30] = {8'h77, 1'b1}; exp_pri[30] = 1'b0;
        verify_entry(0, 8'd30, "R9 ctrl keeps phase");

        // R5 R6: bitmap palette, stepping off, priority stored.
        wr(2'd1, 8'h90);
        wr(2'd0, 8'd40);
        wr(2'd3, 8'h12);
        wr(2'd3, 8'h81);
        rd(2'd0, v); chk("R6 no step on long", {2'b0, v}, 10'd40);
        chk("R5 prio set", {dbg_prio, dbg_colour}, {1'b1, 9'h025});

        // R7: repeated reads leave index and phase untouched.
        wr(2'd3, 8'hC3);
        for (int r = 0; r < 4; r++) begin
            rd(2'd2, v); rd(2'd3, v); rd(2'd0, v);
            chk("R7 read no side effect", {2'b0, v}, 10'd40);
        end
        wr(2'd3, 8'h00);
        chk("R7 phase kept over reads", {dbg_prio, dbg_colour}, {1'b0, 8'hC3, 1'b0});

        done = 1;
        finish_run();
    end

endmodule